// File: doc/BRIEF.md
# Self-Timed Handshake FIFO

This block is a clockless first-in first-out buffer made of a chain of identical handshake stages. Each stage pairs one C-element control cell with one level-sensitive data latch. Items move as bundled data: a binary word travels beside a request wire, and the four-phase return-to-zero handshake moves them. A producer offers words on the input side. A consumer takes them from the output side. When the consumer stops acknowledging, words keep advancing until the chain fills.

Each control cell has two named states, CEL_LOW and CEL_HIGH. The cell takes the RISE transition when its two inputs are both 1. It takes the FALL transition when both are 0. It takes HOLD, keeping its state, when the inputs differ. The first input of stage k is the request from stage k-1; for stage 0 this is the producer's request. The second input is the inverse of stage k+1's control output; for the last stage it is the inverse of the consumer's acknowledge. The cell's output is the acknowledge to the previous stage, the request to the next stage, and the enable of the stage's latch. The latch passes data while its enable is high and holds it while the enable is low.

A global reset forces every cell into CEL_LOW. The stage count is a parameter that must be even and at least 2; any other value stops elaboration. A full chain holds half as many words as it has stages. The producer must keep `data_in` steady from raising `req_in` until `ack_in` has fallen again.

Top module: `muller_fifo`

## Requirements
- R1: While `rst` is high, `ack_in` and `req_out` are both 0, whatever the chain held before.
- R2: `req_out` rises only while `ack_out` is 0, and falls only while `ack_out` is 1.
- R3: `ack_in` rises only while `req_in` is 1, falls only while `req_in` is 0, and stays 1 for as long as `req_in` is held at 1 after the acknowledge.
- R4: When `req_out` is high, `data_out` carries the word of the oldest undelivered item, and it stays unchanged until `req_out` falls.
- R5: Words leave in the order they were accepted, each exactly once, under any mix of producer and consumer handshake delays.
- R6: With the consumer never acknowledging, an empty chain of N stages acknowledges exactly N/2 producer requests; the next request stays unacknowledged for as long as the stall lasts.
- R7: When the consumer resumes after a stall, every stored word and the blocked request are delivered in order.
- R8: After every accepted word has been delivered and handshakes are complete, `ack_in` and `req_out` both return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Global reset, active high; forces every control cell to CEL_LOW |
| req_in | input | 1 | Producer request, four-phase |
| ack_in | output | 1 | Acknowledge to producer (stage 0 control output) |
| data_in | input | WIDTH | Producer word, bundled with `req_in` |
| req_out | output | 1 | Request to consumer (last stage control output) |
| ack_out | input | 1 | Consumer acknowledge, four-phase |
| data_out | output | WIDTH | Word held in the last stage latch |

## Verification
The bench targets the stall point. It checks that an even chain accepts exactly N/2 words and then leaves the next request unacknowledged. A cell that used an AND gate instead of HOLD would accept too many words and overwrite latches. A swapped acknowledge polarity would deadlock or accept too few. Random producer and consumer delays test ordering and the data latched while `req_out` is high; an early latch release would deliver a later word twice or skip one. Reset applied to a filled chain shows whether every cell clears.

// File: rtl/muller_fifo_pkg.sv
package muller_fifo_pkg;

    // Control cell state: output level of a C-element
    typedef enum logic {
        CEL_LOW  = 1'b0,
        CEL_HIGH = 1'b1
    } cel_state_t;

    // Legal chain lengths are even and at least two
    function automatic bit stage_count_ok(input int n);
        return (n >= 2) && ((n % 2) == 0);
    endfunction

    // Words stored by a full chain
    function automatic int chain_capacity(input int n);
        return n / 2;
    endfunction

endpackage

// File: rtl/c_element.sv
module c_element
    import muller_fifo_pkg::*;
(
    input  logic rst,
    input  logic a,
    input  logic b,
    output logic y
);

    cel_state_t st;

    // State holder: RISE on 11, FALL on 00, HOLD otherwise
    always_latch begin
        if (rst) begin
            st = CEL_LOW;
        end else begin
            unique case ({a, b})
                2'b00:   st = CEL_LOW;
                2'b11:   st = CEL_HIGH;
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        y = (st == CEL_HIGH);
    end

endmodule

// File: rtl/stage_latch.sv
module stage_latch #(
    parameter int WIDTH = 8
) (
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Transparent while en is high, holding while en is low
    always_latch begin
        if (en) begin
            q = d;
        end
    end

endmodule

// File: rtl/muller_stage.sv
module muller_stage #(
    parameter int WIDTH = 8
) (
    input  logic             rst,
    input  logic             req_prev,
    input  logic             ctl_next,
    input  logic [WIDTH-1:0] d,
    output logic             ctl,
    output logic [WIDTH-1:0] q
);

    logic next_free;

    // The one inverter of the stage
    always_comb begin
        next_free = ~ctl_next;
    end

    c_element u_cel (
        .rst (rst),
        .a   (req_prev),
        .b   (next_free),
        .y   (ctl)
    );

    stage_latch #(.WIDTH(WIDTH)) u_lat (
        .en (ctl),
        .d  (d),
        .q  (q)
    );

endmodule

// File: rtl/muller_fifo.sv
module muller_fifo #(
    parameter int STAGES = 4,
    parameter int WIDTH  = 8
) (
    input  logic             rst,
    input  logic             req_in,
    output logic             ack_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             req_out,
    input  logic             ack_out,
    output logic [WIDTH-1:0] data_out
);

    localparam int LAST = STAGES - 1;

    generate
        if (!muller_fifo_pkg::stage_count_ok(STAGES)) begin : g_bad_stages
            $error("muller_fifo: STAGES must be even and at least 2");
        end
    endgenerate

    logic [STAGES-1:0] ctl;
    logic [STAGES-1:0] req_v;
    logic [STAGES-1:0] nxt_v;
    logic [WIDTH-1:0]  din [STAGES];
    logic [WIDTH-1:0]  dq  [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign req_v[i] = req_in;
                assign din[i]   = data_in;
            end else begin : g_mid_in
                assign req_v[i] = ctl[i-1];
                assign din[i]   = dq[i-1];
            end

            if (i == LAST) begin : g_tail
                assign nxt_v[i] = ack_out;
            end else begin : g_mid_out
                assign nxt_v[i] = ctl[i+1];
            end

            muller_stage #(.WIDTH(WIDTH)) u_stage (
                .rst      (rst),
                .req_prev (req_v[i]),
                .ctl_next (nxt_v[i]),
                .d        (din[i]),
                .ctl      (ctl[i]),
                .q        (dq[i])
            );
        end
    endgenerate

    assign ack_in   = ctl[0];
    assign req_out  = ctl[LAST];
    assign data_out = dq[LAST];

endmodule

// File: rtl/muller_fifo_chk.sv
module muller_fifo_chk (
    input logic rst,
    input logic req_in,
    input logic ack_in,
    input logic req_out,
    input logic ack_out
);

    // R1: both handshake outputs idle once reset has acted
    always @(negedge rst) begin
        p_reset_idle_r1: assert (!ack_in && !req_out)
            else $error("R1: handshake outputs not idle at reset release");
    end

    // R2: output request rises only while the consumer acknowledge is low
    always @(posedge req_out) begin
        if (!rst) begin
            p_req_out_rise_r2: assert (!ack_out)
                else $error("R2: req_out rose with ack_out high");
        end
    end

    // R2: output request falls only while the consumer acknowledge is high
    always @(negedge req_out) begin
        if (!rst) begin
            p_req_out_fall_r2: assert (ack_out)
                else $error("R2: req_out fell with ack_out low");
        end
    end

    // R3: input acknowledge rises only under a pending request
    always @(posedge ack_in) begin
        if (!rst) begin
            p_ack_in_rise_r3: assert (req_in)
                else $error("R3: ack_in rose without req_in");
        end
    end

    // R3: input acknowledge falls only after the request is withdrawn
    always @(negedge ack_in) begin
        if (!rst) begin
            p_ack_in_fall_r3: assert (!req_in)
                else $error("R3: ack_in fell while req_in high");
        end
    end

endmodule

bind muller_fifo muller_fifo_chk u_chk (
    .rst     (rst),
    .req_in  (req_in),
    .ack_in  (ack_in),
    .req_out (req_out),
    .ack_out (ack_out)
);

// File: tb/muller_fifo_test.sv
module muller_fifo_test;

    localparam int TCK    = 10;
    localparam int STAGES = 4;
    localparam int W      = 8;
    localparam int MAXCYC = 100000;
    localparam int NSTREAM = 60;

    logic clk = 1'b0;
    always #(TCK/2) clk = ~clk;

    logic         rst     = 1'b1;
    logic         req_in  = 1'b0;
    logic         ack_in;
    logic [W-1:0] data_in = '0;
    logic         req_out;
    logic         ack_out = 1'b0;
    logic [W-1:0] data_out;

    muller_fifo #(.STAGES(STAGES), .WIDTH(W)) uut (
        .rst      (rst),
        .req_in   (req_in),
        .ack_in   (ack_in),
        .data_in  (data_in),
        .req_out  (req_out),
        .ack_out  (ack_out),
        .data_out (data_out)
    );

    int           checks = 0;
    int           fails  = 0;
    int           recv   = 0;
    bit           cons_en = 1'b1;
    int           cons_max = 6;
    logic [W-1:0] expq[$];
    logic [W-1:0] seq_val = 8'h10;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic put(input logic [W-1:0] v, input int tmo, input int hold, output bit acked);
        wait (ack_in == 1'b0);
        data_in = v;
        expq.push_back(v);
        #($urandom_range(3, 0));
        req_in = 1'b1;
        acked = 1'b0;
        for (int k = 0; k < tmo; k++) begin
            if (ack_in) begin
                acked = 1'b1;
                break;
            end
            #1;
        end
        if (acked) begin
            #(hold);
            req_in = 1'b0;
            wait (ack_in == 1'b0);
        end
    endtask

    task automatic finish_put();
        wait (ack_in == 1'b1);
        #1;
        req_in = 1'b0;
        wait (ack_in == 1'b0);
    endtask

    // Scoreboard monitor
    initial begin
        logic [W-1:0] exp_v;
        forever begin
            wait (req_out === 1'b1);
            #1;
            if (expq.size() == 0) begin
                check(1'b0, "R5 unexpected extra word", int'(data_out), -1);
                exp_v = data_out;
            end else begin
                exp_v = expq.pop_front();
                check(data_out == exp_v, "R5 order and content", int'(data_out), int'(exp_v));
            end
            recv++;
            #2;
            check(data_out == exp_v, "R4 word steady while req_out high", int'(data_out), int'(exp_v));
            wait (cons_en);
            #($urandom_range(cons_max, 0));
            ack_out = 1'b1;
            wait (req_out == 1'b0);
            #($urandom_range(cons_max, 0));
            ack_out = 1'b0;
        end
    end

    // Watchdog
    initial begin
        repeat (MAXCYC) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", recv, NSTREAM);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit acked;
        int accepted;
        int recv0;

        // R1: reset state
        #7;
        check(ack_in == 1'b0, "R1 ack_in in reset", int'(ack_in), 0);
        check(req_out == 1'b0, "R1 req_out in reset", int'(req_out), 0);
        rst = 1'b0;
        #5;

        // R3: acknowledge held while request stays high
        cons_en = 1'b0;
        data_in = 8'hA5;
        expq.push_back(8'hA5);
        req_in = 1'b1;
        wait (ack_in == 1'b1);
        #20;
        check(ack_in == 1'b1, "R3 ack_in held under req_in", int'(ack_in), 1);
        check(req_out == 1'b1, "R2 req_out raised for first word", int'(req_out), 1);
        req_in = 1'b0;
        wait (ack_in == 1'b0);
        check(ack_in == 1'b0, "R3 ack_in returned to zero", int'(ack_in), 0);
        cons_en = 1'b1;
        wait (expq.size() == 0);
        wait (req_out == 1'b0);

        // R5: random streaming, several delay mixes
        for (int phase = 0; phase < 3; phase++) begin
            cons_max = (phase == 0) ? 1 : (phase == 1) ? 12 : 4;
            for (int n = 0; n < NSTREAM / 3; n++) begin
                put(seq_val, 100000, $urandom_range((phase == 2) ? 10 : 2, 0), acked);
                seq_val = seq_val + 8'd7;
            end
        end
        wait (expq.size() == 0);
        wait (req_out == 1'b0 && ack_out == 1'b0);
        #5;
        check(recv == NSTREAM + 1, "R5 no loss or duplication", recv, NSTREAM + 1);
        check(req_out == 1'b0 && ack_in == 1'b0, "R8 idle after drain", int'({req_out, ack_in}), 0);

        // R6: stall capacity
        cons_en = 1'b0;
        recv0 = recv;
        accepted = 0;
        for (int k = 0; k < STAGES; k++) begin
            put(8'hC0 + 8'(k), 80, 1, acked);
            if (!acked) break;
            accepted++;
        end
        check(accepted == STAGES / 2, "R6 words accepted while stalled", accepted, STAGES / 2);
        #50;
        check(ack_in == 1'b0, "R6 blocked request stays unacknowledged", int'(ack_in), 0);
        check(req_out == 1'b1, "R6 head word offered", int'(req_out), 1);
        check(data_out == 8'hC0, "R4 head word on data_out", int'(data_out), 8'hC0);

        // R7: resume and drain
        cons_en = 1'b1;
        finish_put();
        wait (expq.size() == 0);
        wait (req_out == 1'b0 && ack_out == 1'b0);
        #5;
        check(recv - recv0 == STAGES / 2 + 1, "R7 all stalled words delivered", recv - recv0, STAGES / 2 + 1);
        check(req_out == 1'b0 && ack_in == 1'b0, "R8 idle after stall drain", int'({req_out, ack_in}), 0);

        // R1: reset of a filled chain
        cons_en = 1'b0;
        put(8'h3C, 80, 1, acked);
        put(8'h3D, 80, 1, acked);
        check(req_out == 1'b1, "R1 chain filled before reset", int'(req_out), 1);
        rst = 1'b1;
        #2;
        check(req_out == 1'b0, "R1 req_out cleared by reset", int'(req_out), 0);
        check(ack_in == 1'b0, "R1 ack_in cleared by reset", int'(ack_in), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule